// File: doc/BRIEF.md
# System control register bank

This block is the register file of a privileged system-control coprocessor. A processor-side transfer port presents one request per cycle: a primary register number, a secondary selector, two opcode fields, a read/write flag, the write data and a flag saying the processor is in an unprivileged mode. A legality checker answers every request in the same cycle with an accept flag. Read data for an accepted read is also returned combinationally in that cycle.

An accepted write is reshaped before it is stored. Each register keeps only its writable bits and may force some bits to one. A zero second opcode selects the primary bank. A nonzero second opcode selects the alternate bank, which holds the cache-type word and the auxiliary control. Register 14 uses the secondary selector to reach four debug registers. Writes to the cache, translation-buffer and lock-down function registers are accepted and then dropped.

The stored endianness bit is driven out of the block. A one-cycle pulse reports every change to that bit.

Top module: `scr_bank`

## Requirements
- R1: A request made with `req_user`=1, or with a nonzero `req_op1`, is rejected: `acc_ok`=0, `rdata`=0, and no stored value changes.
- R2: Legality by primary number: 0 and 1 need `req_crm`=0 and accept any `req_op2`. 2, 3, 5, 6 and 13 need `req_crm`=0 and `req_op2`=0. 9 and 10 need `req_op2`=0 and `req_crm` of 0 or 1. 15 needs `req_crm`=1 and `req_op2`=0. 4, 11 and 12 are always rejected.
- R3: Register 7 accepts only these (`req_op2`,`req_crm`) pairs: (6,5), (5,2), (4,10), (1,5), (1,6), (1,10), (0,5), (0,6), (0,7). Register 8 accepts only (0,5), (0,6), (0,7), (1,5) and (1,6).
- R4: Register 14 needs `req_op2`=0 and `req_crm` in {0,3,4,8,9}. `req_crm`=3 selects the second data breakpoint, 4 the breakpoint control, 8 and 9 the two instruction breakpoints, and 0 the first data breakpoint. All of these are fully writable.
- R5: After reset, the following values are read back: the ID (0/op2=0) is 0x69052000, the cache type (0/op2≠0) is 0x0B1AA1AA, the control register (1/op2=0) is 0x00000078, and every other register is zero.
- R6: A control write stores (data & 0x00003B87) | 0x00000078. Writes to the ID and to the cache type leave them unchanged. The auxiliary control (1/op2≠0) stores data & 0x33.
- R7: Write masks: translation base (2) 0xFFFFC000, fault status (5) 0x000006FF, data-cache lock (9) 0x1, process ID (13) 0xFE000000, coprocessor access (15) 0x00003FFF. Domain access (3) and fault address (6) store all 32 bits.
- R8: Writes to registers 7, 8 and 10 are accepted but change no state. Those registers read as zero.
- R9: `big_endian` equals bit 7 of the stored control register. When a control write changes that bit, `mode_change` is high for exactly the one cycle after the write edge.
- R10: `acc_ok` and the read data are valid in the cycle of the request. An accepted write is visible to a read in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | Processor is in an unprivileged mode |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary selector |
| req_op1 | input | 3 | First opcode field, must be zero |
| req_op2 | input | 3 | Second opcode field, bank and function select |
| req_wdata | input | 32 | Write data |
| acc_ok | output | 1 | Request accepted (same cycle) |
| rdata | output | 32 | Read data, zero unless an accepted read |
| big_endian | output | 1 | Stored endianness control bit |
| mode_change | output | 1 | One-cycle pulse after the endianness bit changes |

## Verification
The accept flag and the read data are due in the cycle of the request, so the bench drives each request just after a falling edge and compares both outputs two nanoseconds later, before the next rising edge. A write lands on the following rising edge. The bench updates its reference model only after that edge, so the next request's read check sees the new value. The endianness pulse belongs to the cycle after the write edge. It is therefore compared during the next request's sample window, against a flag the model set at the previous edge.

// File: rtl/scr_pkg.sv
// Package for the system control register bank.
// Holds the data width, the storage slot numbering, and the per-slot
// reset values, write masks and forced-one bits.
// Assumes that slot numbers are dense, running from 0 to NSLOT-1.
package scr_pkg;
    localparam int DW     = 32;
    localparam int NSLOT  = 14;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int ENDIAN_BIT = 7;

    localparam int SL_CTRL  = 0;
    localparam int SL_TTB   = 1;
    localparam int SL_DAC   = 2;
    localparam int SL_FSR   = 3;
    localparam int SL_FAR   = 4;
    localparam int SL_DLOCK = 5;
    localparam int SL_PID   = 6;
    localparam int SL_DBR0  = 7;
    localparam int SL_CPA   = 8;
    localparam int SL_AUX   = 9;
    localparam int SL_DBR1  = 10;
    localparam int SL_DBCON = 11;
    localparam int SL_IBP0  = 12;
    localparam int SL_IBP1  = 13;

    // Bits a write may change, per slot
    function automatic logic [DW-1:0] slot_mask(input int s);
        case (s)
            SL_CTRL:  return 32'h0000_3B87;
            SL_TTB:   return 32'hFFFF_C000;
            SL_FSR:   return 32'h0000_06FF;
            SL_DLOCK: return 32'h0000_0001;
            SL_PID:   return 32'hFE00_0000;
            SL_CPA:   return 32'h0000_3FFF;
            SL_AUX:   return 32'h0000_0033;
            default:  return '1;
        endcase
    endfunction

    // Bits a write always sets, per slot
    function automatic logic [DW-1:0] slot_force(input int s);
        return (s == SL_CTRL) ? 32'h0000_0078 : '0;
    endfunction

    // Value held after reset, per slot
    function automatic logic [DW-1:0] slot_reset(input int s);
        return (s == SL_CTRL) ? 32'h0000_0078 : '0;
    endfunction
endpackage

// File: rtl/scr_legal.sv
// Legality checker: decides whether a request may proceed.
// The decision depends on the privilege flag, the first opcode and a
// per-register matrix over the second opcode and the secondary selector.
// Purely combinational; the caller qualifies the result with its valid flag.
module scr_legal (
    input  logic       user_mode,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op1,
    input  logic [2:0] op2,
    output logic       legal
);
    // Per-register matrix over op2 and crm
    always_comb begin
        legal = 1'b0;
        if (!user_mode && op1 == 3'd0) begin
            case (crn)
                4'd0, 4'd1:               legal = (crm == 4'd0);
                4'd2, 4'd3, 4'd5, 4'd6,
                4'd13:                    legal = (crm == 4'd0) && (op2 == 3'd0);
                4'd7: begin
                    case (op2)
                        3'd0:    legal = (crm >= 4'd5) && (crm <= 4'd7);
                        3'd1:    legal = (crm == 4'd5) || (crm == 4'd6) || (crm == 4'd10);
                        3'd4:    legal = (crm == 4'd10);
                        3'd5:    legal = (crm == 4'd2);
                        3'd6:    legal = (crm == 4'd5);
                        default: legal = 1'b0;
                    endcase
                end
                4'd8:  legal = ((op2 == 3'd0) && (crm >= 4'd5) && (crm <= 4'd7))
                            || ((op2 == 3'd1) && (crm == 4'd5 || crm == 4'd6));
                4'd9, 4'd10: legal = (op2 == 3'd0) && (crm <= 4'd1);
                4'd14: legal = (op2 == 3'd0) && (crm == 4'd0 || crm == 4'd3 ||
                               crm == 4'd4 || crm == 4'd8 || crm == 4'd9);
                4'd15: legal = (op2 == 3'd0) && (crm == 4'd1);
                default: legal = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/scr_slot_map.sv
// Address map: translates (crn, crm, op2) to a storage slot.
// Read and write paths share this map. Registers with no slot (the ID,
// the cache type, and the function registers 7, 8 and 10) report no hit.
// Assumes that legality has been checked elsewhere.
module scr_slot_map
    import scr_pkg::*;
(
    input  logic [3:0]        crn,
    input  logic [3:0]        crm,
    input  logic [2:0]        op2,
    output logic              hit,
    output logic [SLOT_W-1:0] idx
);
    // Pick the storage slot for the addressed register
    always_comb begin
        hit = 1'b1;
        idx = SLOT_W'(SL_CTRL);
        if (op2 != 3'd0) begin
            hit = (crn == 4'd1);
            idx = SLOT_W'(SL_AUX);
        end else begin
            case (crn)
                4'd1:  idx = SLOT_W'(SL_CTRL);
                4'd2:  idx = SLOT_W'(SL_TTB);
                4'd3:  idx = SLOT_W'(SL_DAC);
                4'd5:  idx = SLOT_W'(SL_FSR);
                4'd6:  idx = SLOT_W'(SL_FAR);
                4'd9:  idx = SLOT_W'(SL_DLOCK);
                4'd13: idx = SLOT_W'(SL_PID);
                4'd14: begin
                    case (crm)
                        4'd3:    idx = SLOT_W'(SL_DBR1);
                        4'd4:    idx = SLOT_W'(SL_DBCON);
                        4'd8:    idx = SLOT_W'(SL_IBP0);
                        4'd9:    idx = SLOT_W'(SL_IBP1);
                        default: idx = SLOT_W'(SL_DBR0);
                    endcase
                end
                4'd15: begin
                    hit = (crm == 4'd1);
                    idx = SLOT_W'(SL_CPA);
                end
                default: hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/scr_bank.sv
// System control register bank (top).
// Answers each request in its own cycle with an accept flag and read data.
// An accepted write updates one storage slot at the next clock edge,
// shaped by that slot's mask and forced-one bits.
// Assumes one request per cycle and a synchronous active-low reset.
module scr_bank
    import scr_pkg::*;
#(
    parameter logic [DW-1:0] ID_VALUE    = 32'h6905_2000,
    parameter logic [DW-1:0] CTYPE_VALUE = 32'h0B1A_A1AA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_user,
    input  logic [3:0]    req_crn,
    input  logic [3:0]    req_crm,
    input  logic [2:0]    req_op1,
    input  logic [2:0]    req_op2,
    input  logic [DW-1:0] req_wdata,
    output logic          acc_ok,
    output logic [DW-1:0] rdata,
    output logic          big_endian,
    output logic          mode_change
);
    logic              legal;
    logic              map_hit;
    logic [SLOT_W-1:0] map_idx;
    logic [DW-1:0]     slot_q [NSLOT];
    logic [DW-1:0]     rd_val;
    logic              wr_fire;
    logic [DW-1:0]     ctrl_next;
    logic              pulse_q;

    scr_legal legal_i (
        .user_mode (req_user),
        .crn       (req_crn),
        .crm       (req_crm),
        .op1       (req_op1),
        .op2       (req_op2),
        .legal     (legal)
    );

    scr_slot_map map_i (
        .crn (req_crn),
        .crm (req_crm),
        .op2 (req_op2),
        .hit (map_hit),
        .idx (map_idx)
    );

    assign acc_ok  = req_valid && legal;
    assign wr_fire = acc_ok && req_write && map_hit;

    // One register per slot, each with its own reset value and write shaping
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= slot_reset(g);
            else if (wr_fire && map_idx == SLOT_W'(g))
                slot_q[g] <= (req_wdata & slot_mask(g)) | slot_force(g);
        end
    end

    assign ctrl_next = (req_wdata & slot_mask(SL_CTRL)) | slot_force(SL_CTRL);

    // Pulse for one cycle when a control write flips the endianness bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else
            pulse_q <= wr_fire && (map_idx == SLOT_W'(SL_CTRL)) &&
                       (ctrl_next[ENDIAN_BIT] != slot_q[SL_CTRL][ENDIAN_BIT]);
    end

    // Read selection: constants for ID and cache type, otherwise the mapped slot
    always_comb begin
        rd_val = '0;
        if (req_crn == 4'd0)
            rd_val = (req_op2 == 3'd0) ? ID_VALUE : CTYPE_VALUE;
        else if (map_hit)
            rd_val = slot_q[map_idx];
    end

    assign rdata       = (acc_ok && !req_write) ? rd_val : '0;
    assign big_endian  = slot_q[SL_CTRL][ENDIAN_BIT];
    assign mode_change = pulse_q;
endmodule

// File: rtl/scr_bank_chk.sv
// Checker for scr_bank, bound to every instance. It watches the ports for
// rejection rules, read-data gating and the timing of the endianness pulse.
module scr_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_user,
    input logic [3:0]  req_crn,
    input logic [2:0]  req_op1,
    input logic [2:0]  req_op2,
    input logic        acc_ok,
    input logic [31:0] rdata,
    input logic        big_endian,
    input logic        mode_change
);
    // R1
    user_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_user || req_op1 != 3'd0) |-> !acc_ok);

    // R1
    rdata_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ok |-> rdata == 32'd0);

    // R2
    forbidden_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_crn == 4'd4 || req_crn == 4'd11 || req_crn == 4'd12) |-> !acc_ok);

    // R6
    ctrl_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && !req_write && req_crn == 4'd1 && req_op2 == 3'd0)
        |-> rdata[6:3] == 4'hF);

    // R9
    pulse_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_change |-> big_endian != $past(big_endian));

    // R9
    pulse_required_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (big_endian != $past(big_endian)) |-> mode_change);

    // R10
    no_accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !acc_ok);
endmodule

bind scr_bank scr_bank_chk chk_i (.*);

// File: tb/scr_bank_tb_top.sv
// Bench for scr_bank: directed corner cases followed by seeded random requests,
// all compared against a reference model kept in the bench.
module scr_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [3:0]  req_crn = '0, req_crm = '0;
    logic [2:0]  req_op1 = '0, req_op2 = '0;
    logic [31:0] req_wdata = '0;
    logic        acc_ok, big_endian, mode_change;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [31:0] m_ctrl, m_ttb, m_dac, m_fsr, m_far, m_dl, m_pid, m_cpa, m_aux;
    logic [31:0] m_db0, m_db1, m_dbc, m_ib0, m_ib1;
    logic        exp_pulse;

    always #4 clk = ~clk;

    scr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_user(req_user), .req_crn(req_crn), .req_crm(req_crm),
        .req_op1(req_op1), .req_op2(req_op2), .req_wdata(req_wdata),
        .acc_ok(acc_ok), .rdata(rdata), .big_endian(big_endian),
        .mode_change(mode_change)
    );

    function automatic bit in_set(input int v, input int a, input int b,
                                  input int c, input int d, input int e);
        return v == a || v == b || v == c || v == d || v == e;
    endfunction

    function automatic bit ref_legal(input bit u, input int crn, input int crm,
                                     input int o1, input int o2);
        if (u || o1 != 0) return 0;
        if (crn == 0 || crn == 1) return crm == 0;
        if (in_set(crn, 2, 3, 5, 6, 13)) return crm == 0 && o2 == 0;
        if (crn == 7)
            return (o2 == 0 && in_set(crm, 5, 6, 7, -1, -1)) ||
                   (o2 == 1 && in_set(crm, 5, 6, 10, -1, -1)) ||
                   (o2 == 4 && crm == 10) || (o2 == 5 && crm == 2) ||
                   (o2 == 6 && crm == 5);
        if (crn == 8)
            return (o2 == 0 && in_set(crm, 5, 6, 7, -1, -1)) ||
                   (o2 == 1 && in_set(crm, 5, 6, -1, -1, -1));
        if (crn == 9 || crn == 10) return o2 == 0 && crm < 2;
        if (crn == 14) return o2 == 0 && in_set(crm, 0, 3, 4, 8, 9);
        if (crn == 15) return o2 == 0 && crm == 1;
        return 0;
    endfunction

    function automatic logic [31:0] ref_read(input int crn, input int crm, input int o2);
        if (o2 != 0) return (crn == 0) ? 32'h0B1AA1AA : (crn == 1) ? m_aux : 32'h0;
        case (crn)
            0: return 32'h69052000;
            1: return m_ctrl;
            2: return m_ttb;
            3: return m_dac;
            5: return m_fsr;
            6: return m_far;
            9: return m_dl;
            13: return m_pid;
            14: return (crm == 3) ? m_db1 : (crm == 4) ? m_dbc :
                       (crm == 8) ? m_ib0 : (crm == 9) ? m_ib1 : m_db0;
            15: return (crm == 1) ? m_cpa : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        m_ctrl = 32'h78; m_ttb = 0; m_dac = 0; m_fsr = 0; m_far = 0; m_dl = 0;
        m_pid = 0; m_cpa = 0; m_aux = 0; m_db0 = 0; m_db1 = 0; m_dbc = 0;
        m_ib0 = 0; m_ib1 = 0; exp_pulse = 0;
    endtask

    task automatic model_write(input int crn, input int crm, input int o2,
                               input logic [31:0] d);
        logic [31:0] nc;
        if (o2 != 0) begin
            if (crn == 1) m_aux = d & 32'h33;
            return;
        end
        case (crn)
            1: begin
                nc = (d & 32'h3B87) | 32'h78;
                exp_pulse = nc[7] != m_ctrl[7];
                m_ctrl = nc;
            end
            2: m_ttb = d & 32'hFFFFC000;
            3: m_dac = d;
            5: m_fsr = d & 32'h6FF;
            6: m_far = d;
            9: m_dl = d & 32'h1;
            13: m_pid = d & 32'hFE000000;
            14: case (crm)
                    3: m_db1 = d;
                    4: m_dbc = d;
                    8: m_ib0 = d;
                    9: m_ib1 = d;
                    default: m_db0 = d;
                endcase
            15: m_cpa = d & 32'h3FFF;
            default: ;
        endcase
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one request: drive after falling edge, sample before rising edge, update model after it
    task automatic do_op(input bit w, input bit u, input int crn, input int crm,
                         input int o1, input int o2, input logic [31:0] d,
                         input string req);
        bit ok;
        @(negedge clk);
        req_valid = 1; req_write = w; req_user = u;
        req_crn = 4'(crn); req_crm = 4'(crm); req_op1 = 3'(o1); req_op2 = 3'(o2);
        req_wdata = d;
        #2;
        ok = ref_legal(u, crn, crm, o1, o2);
        check(req, "acc_ok", {31'd0, acc_ok}, {31'd0, ok});
        check(req, "rdata", rdata, (ok && !w) ? ref_read(crn, crm, o2) : 32'h0);
        check("R9", "big_endian", {31'd0, big_endian}, {31'd0, m_ctrl[7]});
        check("R9", "mode_change", {31'd0, mode_change}, {31'd0, exp_pulse});
        @(posedge clk);
        #1;
        exp_pulse = 0;
        if (ok && w) model_write(crn, crm, o2, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R5 reset values
        do_op(0, 0, 0, 0, 0, 0, 0, "R5");
        do_op(0, 0, 0, 0, 0, 3, 0, "R5");
        do_op(0, 0, 1, 0, 0, 0, 0, "R5");
        do_op(0, 0, 3, 0, 0, 0, 0, "R5");
        do_op(0, 0, 14, 9, 0, 0, 0, "R5");
        // R6 control shaping, endianness R9
        do_op(1, 0, 1, 0, 0, 0, 32'hFFFFFFFF, "R6");
        do_op(0, 0, 1, 0, 0, 0, 0, "R6");
        do_op(1, 0, 1, 0, 0, 0, 32'h0, "R9");
        do_op(0, 0, 1, 0, 0, 0, 0, "R9");
        do_op(1, 0, 0, 0, 0, 0, 32'h12345678, "R6");
        do_op(1, 0, 0, 0, 0, 2, 32'h12345678, "R6");
        do_op(0, 0, 0, 0, 0, 0, 0, "R6");
        do_op(0, 0, 0, 0, 0, 2, 0, "R6");
        do_op(1, 0, 1, 0, 0, 1, 32'hFFFFFFFF, "R6");
        do_op(0, 0, 1, 0, 0, 5, 0, "R6");
        // R7 masks
        for (int r = 0; r < 16; r++) begin
            do_op(1, 0, r, (r == 15) ? 1 : 0, 0, 0, 32'hFFFFFFFF, "R7");
            do_op(0, 0, r, (r == 15) ? 1 : 0, 0, 0, 0, "R7");
        end
        // R4 debug registers
        for (int c = 0; c < 10; c++) do_op(1, 0, 14, c, 0, 0, 32'hA5000000 + c, "R4");
        for (int c = 0; c < 10; c++) do_op(0, 0, 14, c, 0, 0, 0, "R4");
        // R1 rejection: privilege and op1; reads follow to show no change
        do_op(1, 1, 3, 0, 0, 0, 32'h0BAD0BAD, "R1");
        do_op(1, 0, 3, 0, 2, 0, 32'h0BAD0BAD, "R1");
        do_op(0, 0, 3, 0, 0, 0, 0, "R1");
        do_op(0, 1, 3, 0, 0, 0, 0, "R1");
        // R2 / R3 / R8 legality sweep for the matrix registers
        for (int o = 0; o < 8; o++)
            for (int c = 0; c < 16; c++) begin
                do_op(1, 0, 7, c, 0, o, 32'hFFFF, "R3");
                do_op(0, 0, 8, c, 0, o, 0, "R3");
                do_op(1, 0, 10, c, 0, o, 32'hFFFF, "R8");
                do_op(0, 0, 4 + 7 * (c % 2), c, 0, o, 0, "R2");
                do_op(0, 0, 15, c, 0, o, 0, "R2");
            end
        // R10 back-to-back write then read
        do_op(1, 0, 6, 0, 0, 0, 32'hCAFEF00D, "R10");
        do_op(0, 0, 6, 0, 0, 0, 0, "R10");
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int crn, crm, o1, o2;
            bit w, u;
            crn = $urandom % 16;
            crm = ($urandom % 2) ? ($urandom % 11) : ($urandom % 16);
            o2  = ($urandom % 2) ? 0 : ($urandom % 8);
            o1  = ($urandom % 8 == 0) ? ($urandom % 8) : 0;
            u   = ($urandom % 10 == 0);
            w   = $urandom % 2;
            do_op(w, u, crn, crm, o1, o2, $urandom, "R2");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule